// File: doc/BRIEF.md
# Compare Match Output Pin Unit

This block connects a timer's compare-match event to one I/O pin. It keeps a single output-compare state bit. Whenever the comparator signals a match, the block updates that bit according to a 2-bit output mode: hold it, toggle it, clear it or set it. Software can also load the bit directly, so the pin starts from a known level before the compare logic takes it over.

In non-PWM operation, a one-cycle force strobe applies the configured action at once, just as a real match would. The pin multiplexer routes the state bit to the pin data whenever the mode is non-zero. Otherwise the pin carries the general-purpose port latch. The pin output enable always follows the separate direction bit. The counter, the comparator and the PWM counting sequences sit outside this block.

Top module: `ocmp_pin_unit`

## Requirements
- R1: While rst_ni is low the state bit is 0. With a non-zero mode and dir_i=1 the pin then reads 0.
- R2: pin_o equals the state bit when com_i is not 00. When com_i is 00, pin_o equals port_data_i.
- R3: pin_oe_o equals dir_i for every value of com_i.
- R4: With com_i=00, an applied action (a match, or a force in non-PWM mode) leaves the state bit unchanged.
- R5: A change of com_i with no match, force or preset never changes the state bit. The value of com_i present at a match is the one that acts on it.
- R6: At a match the state bit changes after the clock edge as follows: com_i=01 inverts it, 10 makes it 0, 11 makes it 1. This holds whatever the value of pwm_mode_i.
- R7: A force strobe with pwm_mode_i=0 applies the action of R6 at the next edge. A force that coincides with a match applies the action only once.
- R8: A force strobe with pwm_mode_i=1 has no effect on the state bit.
- R9: With no match and no effective force, preset_we_i=1 loads preset_data_i into the state bit at the next edge.
- R10: When a preset write and an applied action land in the same cycle, the action decides the new state and preset_data_i is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_match_i | input | 1 | One-cycle compare-match pulse from the comparator |
| com_i | input | 2 | Compare-output mode: 00 none, 01 toggle, 10 clear, 11 set |
| pwm_mode_i | input | 1 | High when the timer runs a PWM sequence |
| force_i | input | 1 | One-cycle force-compare strobe |
| dir_i | input | 1 | Pin direction, 1 = output |
| port_data_i | input | 1 | General-purpose port latch value |
| preset_we_i | input | 1 | Write strobe that loads the state bit |
| preset_data_i | input | 1 | Value loaded by a preset write |
| pin_o | output | 1 | Pin data value |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The block has no size parameters: the mode width is fixed at two bits. The bench therefore builds the single default configuration. This lets it sweep every combination of prior state, mode, PWM flag, match, force, preset write and preset value, 256 cases in all, against an arithmetic model. It also walks all mode, port and direction combinations through the pin multiplexer. This covers every priority collision, including a match colliding with a force and either of them colliding with a preset.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int unsigned COM_W = 2;

  typedef enum logic [COM_W-1:0] {
    OCM_HOLD   = 2'b00,
    OCM_TOGGLE = 2'b01,
    OCM_CLEAR  = 2'b10,
    OCM_SET    = 2'b11
  } ocm_e;

  function automatic logic ocm_next(input ocm_e mode, input logic cur);
    unique case (mode)
      OCM_HOLD:   return cur;
      OCM_TOGGLE: return ~cur;
      OCM_CLEAR:  return 1'b0;
      default:    return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/ocmp_action_reg.sv
module ocmp_action_reg
  import ocmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_match_i,
  input  logic [COM_W-1:0] com_i,
  input  logic             pwm_mode_i,
  input  logic             force_i,
  input  logic             preset_we_i,
  input  logic             preset_data_i,
  output logic             state_o
);
  logic act;
  logic state_q, state_d;
  ocm_e mode;

  assign mode = ocm_e'(com_i);
  // force only counts outside PWM; a coincident match gives one action
  assign act  = cmp_match_i | (force_i & ~pwm_mode_i);

  always_comb begin
    state_d = state_q;
    if (act)              state_d = ocm_next(mode, state_q);
    else if (preset_we_i) state_d = preset_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= 1'b0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_HOLD_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && com_i == 2'b00) |=> $stable(state_q)); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_match_i && !force_i && !preset_we_i) |=> $stable(state_q)); // R5
  AST_MATCH_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_match_i && com_i == 2'b01) |=> (state_q != $past(state_q))); // R6
  AST_MATCH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_match_i && com_i == 2'b10) |=> !state_q); // R6
  AST_MATCH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_match_i && com_i == 2'b11) |=> state_q); // R6
  AST_FORCE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !pwm_mode_i && com_i == 2'b11) |=> state_q); // R7
  AST_FORCE_PWM_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && pwm_mode_i && !cmp_match_i && !preset_we_i) |=> $stable(state_q)); // R8
  AST_PRESET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preset_we_i && !cmp_match_i && !(force_i && !pwm_mode_i)) |=> (state_q == $past(preset_data_i))); // R9
  AST_MATCH_BEATS_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_match_i && preset_we_i && com_i == 2'b00) |=> $stable(state_q)); // R10
endmodule

// File: rtl/ocmp_pin_mux.sv
module ocmp_pin_mux
  import ocmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [COM_W-1:0] com_i,
  input  logic             state_i,
  input  logic             dir_i,
  input  logic             port_data_i,
  output logic             pin_o,
  output logic             pin_oe_o
);
  logic owned;

  assign owned    = |com_i;
  assign pin_o    = owned ? state_i : port_data_i;
  assign pin_oe_o = dir_i;

  AST_PIN_PORT_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com_i == 2'b00) |-> (pin_o == port_data_i)); // R2
  AST_PIN_CMP_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com_i != 2'b00) |-> (pin_o == state_i)); // R2
endmodule

// File: rtl/ocmp_pin_unit.sv
module ocmp_pin_unit
  import ocmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_match_i,
  input  logic [COM_W-1:0] com_i,
  input  logic             pwm_mode_i,
  input  logic             force_i,
  input  logic             dir_i,
  input  logic             port_data_i,
  input  logic             preset_we_i,
  input  logic             preset_data_i,
  output logic             pin_o,
  output logic             pin_oe_o
);
  logic state;

  ocmp_action_reg u_action (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmp_match_i   (cmp_match_i),
    .com_i         (com_i),
    .pwm_mode_i    (pwm_mode_i),
    .force_i       (force_i),
    .preset_we_i   (preset_we_i),
    .preset_data_i (preset_data_i),
    .state_o       (state)
  );

  ocmp_pin_mux u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .com_i       (com_i),
    .state_i     (state),
    .dir_i       (dir_i),
    .port_data_i (port_data_i),
    .pin_o       (pin_o),
    .pin_oe_o    (pin_oe_o)
  );

  AST_RESET_LOW: assert property (@(posedge clk_i)
    (!rst_ni && com_i != 2'b00) |-> !pin_o); // R1
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o == dir_i); // R3
endmodule

// File: tb/ocmp_pin_unit_tb_top.sv
module ocmp_pin_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic match = 1'b0, pwm = 1'b0, frc = 1'b0, dir = 1'b0, port = 1'b0;
  logic we = 1'b0, wd = 1'b0;
  logic [1:0] com = 2'b00;
  logic pin, oe;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ocmp_pin_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_match_i(match), .com_i(com),
    .pwm_mode_i(pwm), .force_i(frc), .dir_i(dir), .port_data_i(port),
    .preset_we_i(we), .preset_data_i(wd), .pin_o(pin), .pin_oe_o(oe)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic model(input logic cur, input logic [1:0] c, input logic p,
                                 input logic m, input logic f, input logic w, input logic d);
    if (m || (f && !p)) begin
      case (c)
        2'b00: return cur;
        2'b01: return !cur;
        2'b10: return 1'b0;
        default: return 1'b1;
      endcase
    end
    if (w) return d;
    return cur;
  endfunction

  task automatic preset(input logic v);
    @(negedge clk);
    match = 0; frc = 0; com = 2'b00; we = 1; wd = v;
    @(negedge clk);
    we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    dir = 1; com = 2'b11;
    #1;
    check("R1", pin, 1'b0);
    repeat (2) @(negedge clk);
    check("R1", pin, 1'b0);
    rst_n = 1;
    @(negedge clk);
    #1 check("R1", pin, 1'b0);

    // pin multiplexer sweep with known state
    for (int s = 0; s < 2; s++) begin
      preset(s[0]);
      for (int c = 0; c < 4; c++)
        for (int pd = 0; pd < 2; pd++)
          for (int dr = 0; dr < 2; dr++) begin
            com = c[1:0]; port = pd[0]; dir = dr[0];
            #1;
            check("R2", pin, (c != 0) ? s[0] : pd[0]);
            check("R3", oe, dr[0]);
          end
    end

    // exhaustive action sweep
    for (int idx = 0; idx < 256; idx++) begin
      logic cur, p, m, f, w, d, exp;
      logic [1:0] c;
      string req;
      cur = idx[0]; c = idx[2:1]; p = idx[3]; m = idx[4];
      f = idx[5]; w = idx[6]; d = idx[7];
      preset(cur);
      com = c; pwm = p; match = m; frc = f; we = w; wd = d;
      @(negedge clk);
      match = 0; frc = 0; we = 0; com = 2'b01;
      #1;
      exp = model(cur, c, p, m, f, w, d);
      if ((m || (f && !p)) && w)       req = "R10";
      else if (f && p && !m)           req = "R8";
      else if (f && !p)                req = (c == 0) ? "R4" : "R7";
      else if (m)                      req = (c == 0) ? "R4" : "R6";
      else if (w)                      req = "R9";
      else                             req = "R5";
      check(req, pin, exp);
    end

    // mode change alone, then applied at next match
    preset(1'b1);
    com = 2'b10; @(negedge clk); com = 2'b01; #1;
    check("R5", pin, 1'b1);
    com = 2'b10; match = 1; @(negedge clk); match = 0; com = 2'b01; #1;
    check("R5", pin, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule